// File: doc/BRIEF.md
# Inbound Interrupt Write Forwarder

This block sits between the downstream I/O ports and the upstream path toward the processor bus. It takes inbound posted memory writes, each with an address, data and a semantic tag. It stores them in an ordered inbound buffer. When the buffer has no free entry, it refuses a write with a retry pulse. Each write is classified once, on entry. A write that targets the interrupt message address window and carries an eligible tag is marked as an interrupt message. Every other write stays an ordinary memory write.

The upstream side is one ordered valid/ready channel. It carries the address, the data and a one-bit transaction type. All entries leave in the order in which they were accepted. An interrupt message therefore cannot overtake posted data that entered before it. This ordering is what makes the interrupt push earlier traffic ahead of itself.

Top module: `irq_write_forwarder`

## Requirements
- R1: A write whose address bits [31:20] equal 0xFEE and whose tag is eligible leaves upstream with upType = 1 (interrupt message).
- R2: The tag encoding is 2'b00 = ordinary PCI semantic and 2'b01 = south-bridge link, and both are eligible. Tags 2'b10 and 2'b11 are not eligible, so a write carrying them leaves with upType = 0 even when its address is inside the window.
- R3: A write whose address bits [31:20] differ from 0xFEE leaves with upType = 0 (memory write), whatever its tag.
- R4: While fewer than DEPTH entries are held, inReady is 1. A write with inValid high is accepted at that clock edge, and its address and data appear on the upstream port from the following cycle.
- R5: When the buffer holds DEPTH entries and inValid is high, inRetry is 1 and inReady is 0 in the same cycle. The retried write is not stored.
- R6: Entries leave upstream in the order in which they were accepted. An interrupt message is presented only after every write accepted before it has been taken.
- R7: While upValid is 1 and upReady is 0, upValid, upAddr, upData and upType hold their values.
- R8: Reset empties the buffer. After reset, upValid is 0, inReady is 1 and inRetry is 0.
- R9: The buffer holds exactly DEPTH entries (default 8). All DEPTH entries are accepted and later delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Inbound write request |
| inAddr | input | 32 | Inbound write address |
| inData | input | 32 | Inbound write data |
| inTag | input | 2 | Semantic tag (00 PCI, 01 link, 10/11 other) |
| inReady | output | 1 | Buffer has a free entry |
| inRetry | output | 1 | Request refused because the buffer is full |
| upValid | output | 1 | Upstream entry available |
| upReady | input | 1 | Upstream consumer takes the entry |
| upAddr | output | 32 | Upstream address |
| upData | output | 32 | Upstream data |
| upType | output | 1 | 1 = interrupt message, 0 = memory write |

## Verification
Assertions check three things on every cycle. The upstream fields stay stable under backpressure. Every presented interrupt message has an address inside the window. The occupancy never exceeds the depth and does not change on a retry. Only the bench scenarios can show that tag eligibility is honoured, that a retried write really disappears, and that an interrupt message queued behind a full buffer of data leaves last. They do this by filling the buffer, provoking a retry and draining it in order.

// File: rtl/iwf_pkg.sv
package iwf_pkg;
  localparam logic [11:0] IRQ_WINDOW = 12'hFEE;
  localparam logic [1:0]  TAG_PCI    = 2'b00;
  localparam logic [1:0]  TAG_LINK   = 2'b01;

  typedef struct packed {
    logic push;
    logic pop;
  } iwf_strobe_t;
endpackage

// File: rtl/iwf_ctrl.sv
module iwf_ctrl
  import iwf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        upReady,
  output logic        inReady,
  output logic        inRetry,
  output logic        upValid,
  output iwf_strobe_t strobe
);
  localparam int CntW = $clog2(DEPTH + 1);
  localparam logic [CntW-1:0] DepthC = CntW'(DEPTH);

  logic [CntW-1:0] count;
  logic full, empty;

  assign full    = (count == DepthC);
  assign empty   = (count == '0);
  assign inReady = !full;
  assign inRetry = inValid && full;
  assign upValid = !empty;

  always_comb begin
    strobe.push = inValid && !full;
    strobe.pop  = !empty && upReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= DepthC);

  // R5
  retry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inRetry && !upReady) |=> $stable(count));
endmodule

// File: rtl/iwf_datapath.sv
module iwf_datapath
  import iwf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  iwf_strobe_t   strobe,
  input  logic [AW-1:0] inAddr,
  input  logic [DW-1:0] inData,
  input  logic [1:0]    inTag,
  input  logic          upValid,
  output logic [AW-1:0] upAddr,
  output logic [DW-1:0] upData,
  output logic          upType
);
  localparam int PtrW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PtrW-1:0] LastP = PtrW'(DEPTH - 1);

  logic [AW-1:0] addrMem [DEPTH];
  logic [DW-1:0] dataMem [DEPTH];
  logic [DEPTH-1:0] irqMem;
  logic [PtrW-1:0] wrPtr, rdPtr;
  logic inWindow, tagOk, isIrq;

  assign inWindow = (inAddr[AW-1:AW-12] == IRQ_WINDOW);
  assign tagOk    = (inTag == TAG_PCI) || (inTag == TAG_LINK);
  assign isIrq    = inWindow && tagOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LastP) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= (rdPtr == LastP) ? '0 : rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      addrMem[wrPtr] <= inAddr;
      dataMem[wrPtr] <= inData;
      irqMem[wrPtr]  <= isIrq;
    end
  end

  assign upAddr = addrMem[rdPtr];
  assign upData = dataMem[rdPtr];
  assign upType = irqMem[rdPtr];

  // R1 R3
  irq_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && upType) |-> (upAddr[AW-1:AW-12] == IRQ_WINDOW));
endmodule

// File: rtl/irq_write_forwarder.sv
module irq_write_forwarder
  import iwf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [AW-1:0] inAddr,
  input  logic [DW-1:0] inData,
  input  logic [1:0]    inTag,
  output logic          inReady,
  output logic          inRetry,
  output logic          upValid,
  input  logic          upReady,
  output logic [AW-1:0] upAddr,
  output logic [DW-1:0] upData,
  output logic          upType
);
  iwf_strobe_t strobe;

  iwf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .upReady(upReady),
    .inReady(inReady), .inRetry(inRetry), .upValid(upValid), .strobe(strobe)
  );

  iwf_datapath #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inAddr(inAddr),
    .inData(inData), .inTag(inTag), .upValid(upValid),
    .upAddr(upAddr), .upData(upData), .upType(upType)
  );

  // R7
  up_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && !upReady) |=> (upValid && $stable(upAddr) &&
                               $stable(upData) && $stable(upType)));

  // R5
  retry_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    inRetry |-> !inReady);
endmodule

// File: tb/irq_write_forwarder_tb_top.sv
module irq_write_forwarder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] inAddr = '0;
  logic [31:0] inData = '0;
  logic [1:0] inTag = '0;
  logic inReady, inRetry, upValid, upType;
  logic upReady = 1'b0;
  logic [31:0] upAddr, upData;

  int nTests = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_write_forwarder #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inAddr(inAddr),
    .inData(inData), .inTag(inTag), .inReady(inReady), .inRetry(inRetry),
    .upValid(upValid), .upReady(upReady), .upAddr(upAddr),
    .upData(upData), .upType(upType)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] d;
    logic [1:0]  t;
    logic        e;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'hFEE0_0010, 32'h0000_0041, 2'b00, 1'b1},  // R1 PCI in window
    '{32'hFEEF_FFFC, 32'h0000_0042, 2'b01, 1'b1},  // R1 R2 link in window
    '{32'hFEE1_2340, 32'h0000_0043, 2'b10, 1'b0},  // R2 other tag
    '{32'hFEE0_0000, 32'h0000_0044, 2'b11, 1'b0},  // R2 other tag
    '{32'hFED0_0000, 32'h0000_0045, 2'b00, 1'b0},  // R3 below window
    '{32'hFEF0_0000, 32'h0000_0046, 2'b01, 1'b0},  // R3 above window
    '{32'h1000_0000, 32'h0000_0047, 2'b00, 1'b0},  // R3 plain memory
    '{32'h0FEE_0000, 32'h0000_0048, 2'b00, 1'b0}   // R3 window bits shifted
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pushOne(input logic [31:0] a, input logic [31:0] d, input logic [1:0] t);
    @(negedge clk);
    inValid = 1'b1; inAddr = a; inData = d; inTag = t;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 upValid in reset", {31'b0, upValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R8 upValid", {31'b0, upValid}, 32'd0);
    chk("R8 inReady", {31'b0, inReady}, 32'd1);
    chk("R8 inRetry", {31'b0, inRetry}, 32'd0);

    // Table walk: R1 R2 R3 R4
    for (int i = 0; i < 8; i++) begin
      pushOne(VECS[i].a, VECS[i].d, VECS[i].t);
      chk("R4 upValid", {31'b0, upValid}, 32'd1);
      chk("R4 upAddr", upAddr, VECS[i].a);
      chk("R4 upData", upData, VECS[i].d);
      chk("R1 R2 R3 upType", {31'b0, upType}, {31'b0, VECS[i].e});
      upReady = 1'b1;
      @(negedge clk);
      upReady = 1'b0;
      chk("R4 drained", {31'b0, upValid}, 32'd0);
    end

    // R9 fill: seven data writes, then an interrupt message
    for (int i = 0; i < DEPTH; i++) begin
      chk("R4 inReady before fill", {31'b0, inReady}, 32'd1);
      if (i == DEPTH - 1) pushOne(32'hFEE0_1000, 32'hA5A5_0000, 2'b00);
      else pushOne(32'h2000_0000 + 32'(i*4), 32'h0000_1000 + 32'(i), 2'b00);
    end
    chk("R9 full inReady", {31'b0, inReady}, 32'd0);
    // R5 retry when full
    @(negedge clk);
    inValid = 1'b1; inAddr = 32'hFEE0_2000; inData = 32'hDEAD_BEEF; inTag = 2'b01;
    #1;
    chk("R5 inRetry", {31'b0, inRetry}, 32'd1);
    chk("R5 inReady", {31'b0, inReady}, 32'd0);
    @(negedge clk);
    inValid = 1'b0;
    // R7 stall: head stays the first data write
    repeat (3) @(negedge clk);
    chk("R7 upValid held", {31'b0, upValid}, 32'd1);
    chk("R7 upAddr held", upAddr, 32'h2000_0000);
    chk("R7 upData held", upData, 32'h0000_1000);
    chk("R7 upType held", {31'b0, upType}, 32'd0);
    // R6 drain in order, interrupt last
    upReady = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) begin
        chk("R6 irq addr", upAddr, 32'hFEE0_1000);
        chk("R6 irq type", {31'b0, upType}, 32'd1);
      end else begin
        chk("R6 data addr", upAddr, 32'h2000_0000 + 32'(i*4));
        chk("R6 data type", {31'b0, upType}, 32'd0);
      end
      chk("R9 entry valid", {31'b0, upValid}, 32'd1);
      @(negedge clk);
    end
    upReady = 1'b0;
    chk("R5 retried write not stored", {31'b0, upValid}, 32'd0);

    // R8 reset while holding entries
    pushOne(32'h3000_0000, 32'h1, 2'b00);
    pushOne(32'hFEE0_0000, 32'h2, 2'b01);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R8 reset empties", {31'b0, upValid}, 32'd0);
    chk("R8 inReady after reset", {31'b0, inReady}, 32'd1);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule